// File: doc/BRIEF.md
# RDMA Write Header Sequencer

This block walks a stream of fixed-length payload blocks and turns each one into the set of per-packet header fields for a RoCEv2 RDMA write. One block becomes one packet. Every block arrives with a start strobe and a block sequence number. For each accepted block the sequencer produces the following: the BTH opcode, the packet sequence number, whether an RDMA extended transport header (RETH) is present, the RETH contents (virtual address, remote key and DMA length), whether an immediate word is present, the immediate value, the total header length, and the IP and UDP length fields.

Packets are grouped into messages of a programmable size. In a multi-packet message the opcodes step through first, middle and last. When a message holds a single packet, the write-only opcodes are used instead. The virtual address moves forward by the DMA length from one message to the next and returns to the start address after a programmable number of messages. A simple write-only register port sets the configuration. The header fields sit in an output register, flagged by a valid strobe, until the downstream serialiser acknowledges them. Byte serialisation, checksums and the ICRC are done elsewhere.

Top module: `rdma_wr_hdr_seq`

## Requirements
- R1: With packets-per-message N > 1, packet index 0 of a message carries opcode 0x26, indices 1..N-2 carry 0x27, and index N-1 carries 0x28.
- R2: When flag bit 0 (use immediate) is set and N > 1, the final packet of each message carries opcode 0x29 in place of 0x28.
- R3: With N = 1, or N = 0, which is treated as 1, every packet carries 0x2A, or 0x2B when flag bit 0 is set.
- R4: The packet sequence number output equals the lower 24 bits of the block sequence number sampled on the accepting clock edge.
- R5: The RETH-present output is high only for opcodes 0x26, 0x2A and 0x2B. When it is high, the remote key and DMA length outputs show the configured values.
- R6: The virtual address equals start + dma_length × (message index mod message count), where the message index counts from the last clear. A message count of 0 is treated as 1.
- R7: The immediate-present output is high only for opcodes 0x29 and 0x2B. The immediate value is the message index when flag bit 1 is set, and the configured immediate value otherwise.
- R8: Header length is 54 bytes, plus 16 when a RETH is present, plus 4 when an immediate is present. With frame = header + payload + 4 (ICRC), the IP total length is frame − 14 and the UDP length is frame − 34.
- R9: A block is accepted only when its start strobe is high while ready is high. Ready is low while a header is pending and during any configuration write cycle. Only accepted blocks advance the packet and message counters.
- R10: Any configuration write resets the packet index and the message index to zero, so the next accepted block starts a new message with message index 0.
- R11: Once valid, the header output stays valid and holds its value until acknowledged. Valid drops on the edge that samples the acknowledge, and ready returns high in the following cycle.
- R12: After reset the valid output is low, ready is high, and the counters are zero. The defaults are packets-per-message 1, message count 1, and all other registers 0.
- R13: Configuration addresses: 0 packets-per-message, 1 message count, 2 start address low word, 3 start address high word, 4 DMA length, 5 remote key, 6 immediate value, 7 flags (bit 0 use immediate, bit 1 immediate from message index), 8 payload bytes per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| blk_valid_i | input | 1 | Start of a payload block |
| blk_bsn_i | input | 24 | Block sequence number |
| blk_ready_o | output | 1 | Block can be accepted |
| hdr_valid_o | output | 1 | Header fields valid |
| hdr_ack_i | input | 1 | Downstream acknowledges header |
| hdr_opcode_o | output | 8 | BTH opcode |
| hdr_psn_o | output | 24 | Packet sequence number |
| hdr_has_reth_o | output | 1 | RETH present |
| hdr_vaddr_o | output | 64 | RETH virtual address |
| hdr_rkey_o | output | 32 | RETH remote key |
| hdr_dma_len_o | output | 32 | RETH DMA length |
| hdr_has_imm_o | output | 1 | Immediate word present |
| hdr_imm_o | output | 32 | Immediate value |
| hdr_len_o | output | 16 | Header length in bytes |
| ip_total_len_o | output | 16 | IP total length field |
| udp_len_o | output | 16 | UDP length field |

## Verification
A packet index that has drifted shows up at once as a wrong opcode on the next header. A middle packet appears where a first or last is expected, and the RETH and immediate flags and the header length go wrong with it. A wrong message index or wrap value does not affect the opcodes. It shows only in the virtual address and the message-index immediate, and only on packets that carry a RETH or an immediate, which may be several packets later. For that reason the bench checks those fields across a full wrap cycle. A counter that moves on a refused block shifts the opcode pattern by one from the next accepted header onward.

// File: rtl/rdma_hdr_pkg.sv
package rdma_hdr_pkg;
  localparam logic [7:0] OP_FIRST    = 8'h26;
  localparam logic [7:0] OP_MID      = 8'h27;
  localparam logic [7:0] OP_LAST     = 8'h28;
  localparam logic [7:0] OP_LAST_IMM = 8'h29;
  localparam logic [7:0] OP_ONLY     = 8'h2A;
  localparam logic [7:0] OP_ONLY_IMM = 8'h2B;

  localparam int BASE_HDR_B = 54;
  localparam int RETH_B     = 16;
  localparam int IMM_B      = 4;
  localparam int ICRC_B     = 4;
  localparam int ETH_B      = 14;
  localparam int ETH_IP_B   = 34;

  // fixed IP/UDP values for the serialiser
  localparam int IP_VERSION   = 4;
  localparam int IP_IHL       = 5;
  localparam int IP_TTL       = 127;
  localparam int IP_FLAGS     = 2;
  localparam int IP_PROTO_UDP = 17;
  localparam int UDP_DPORT    = 4791;

  typedef enum logic [3:0] {
    CA_PPM    = 4'd0,
    CA_NMSG   = 4'd1,
    CA_SA_LO  = 4'd2,
    CA_SA_HI  = 4'd3,
    CA_DMA    = 4'd4,
    CA_RKEY   = 4'd5,
    CA_IMM    = 4'd6,
    CA_FLAGS  = 4'd7,
    CA_PAYLD  = 4'd8
  } cfg_addr_e;

  typedef struct packed {
    logic imm_is_cnt;
    logic use_imm;
  } flags_t;
endpackage

// File: rtl/rdma_hdr_cnt.sv
module rdma_hdr_cnt #(
  parameter int CNT_W = 16,
  parameter int MSG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] ppm_i,
  input  logic [CNT_W-1:0] nmsg_i,
  output logic [MSG_W-1:0] msg_cnt_o,
  output logic [CNT_W-1:0] msg_wrap_o,
  output logic             first_o,
  output logic             last_o
);
  logic [CNT_W-1:0] pkt_idx_q, wrap_q, ppm_eff, nmsg_eff;
  logic [MSG_W-1:0] msg_q;
  logic             wrap_end;

  assign ppm_eff  = (ppm_i  == '0) ? CNT_W'(1) : ppm_i;
  assign nmsg_eff = (nmsg_i == '0) ? CNT_W'(1) : nmsg_i;
  assign first_o  = (pkt_idx_q == '0);
  assign last_o   = (pkt_idx_q >= ppm_eff - CNT_W'(1));
  assign wrap_end = (wrap_q >= nmsg_eff - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_idx_q <= '0;
      wrap_q    <= '0;
      msg_q     <= '0;
    end else if (clr_i) begin
      pkt_idx_q <= '0;
      wrap_q    <= '0;
      msg_q     <= '0;
    end else if (step_i) begin
      if (last_o) begin
        pkt_idx_q <= '0;
        msg_q     <= msg_q + MSG_W'(1);
        wrap_q    <= wrap_end ? '0 : wrap_q + CNT_W'(1);
      end else begin
        pkt_idx_q <= pkt_idx_q + CNT_W'(1);
      end
    end
  end

  assign msg_cnt_o  = msg_q;
  assign msg_wrap_o = wrap_q;
endmodule

// File: rtl/rdma_hdr_opsel.sv
module rdma_hdr_opsel
  import rdma_hdr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             first_i,
  input  logic             last_i,
  input  logic             use_imm_i,
  output logic [7:0]       opcode_o,
  output logic             has_reth_o,
  output logic             has_imm_o,
  output logic [LEN_W-1:0] hdr_len_o
);
  always_comb begin
    if (first_i && last_i)  opcode_o = use_imm_i ? OP_ONLY_IMM : OP_ONLY;
    else if (first_i)       opcode_o = OP_FIRST;
    else if (last_i)        opcode_o = use_imm_i ? OP_LAST_IMM : OP_LAST;
    else                    opcode_o = OP_MID;
  end

  assign has_reth_o = first_i;
  assign has_imm_o  = last_i && use_imm_i;
  assign hdr_len_o  = LEN_W'(BASE_HDR_B)
                    + (has_reth_o ? LEN_W'(RETH_B) : '0)
                    + (has_imm_o  ? LEN_W'(IMM_B)  : '0);
endmodule

// File: rtl/rdma_hdr_vaddr.sv
module rdma_hdr_vaddr #(
  parameter int AW    = 64,
  parameter int DW    = 32,
  parameter int IDX_W = 16
) (
  input  logic [AW-1:0]    start_i,
  input  logic [DW-1:0]    dma_len_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    vaddr_o
);
  assign vaddr_o = start_i + AW'(dma_len_i) * AW'(idx_i);
endmodule

// File: rtl/rdma_wr_hdr_seq.sv
module rdma_wr_hdr_seq
  import rdma_hdr_pkg::*;
#(
  parameter int PSN_W  = 24,
  parameter int CFG_AW = 4,
  parameter int DW     = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  input  logic              blk_valid_i,
  input  logic [PSN_W-1:0]  blk_bsn_i,
  output logic              blk_ready_o,
  output logic              hdr_valid_o,
  input  logic              hdr_ack_i,
  output logic [7:0]        hdr_opcode_o,
  output logic [PSN_W-1:0]  hdr_psn_o,
  output logic              hdr_has_reth_o,
  output logic [2*DW-1:0]   hdr_vaddr_o,
  output logic [DW-1:0]     hdr_rkey_o,
  output logic [DW-1:0]     hdr_dma_len_o,
  output logic              hdr_has_imm_o,
  output logic [DW-1:0]     hdr_imm_o,
  output logic [LEN_W-1:0]  hdr_len_o,
  output logic [LEN_W-1:0]  ip_total_len_o,
  output logic [LEN_W-1:0]  udp_len_o
);
  localparam int AW = 2 * DW;

  logic [CNT_W-1:0] ppm_q, nmsg_q, payld_q;
  logic [DW-1:0]    sa_lo_q, sa_hi_q, dma_q, rkey_q, imm_q;
  flags_t           flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppm_q   <= CNT_W'(1);
      nmsg_q  <= CNT_W'(1);
      payld_q <= '0;
      sa_lo_q <= '0;
      sa_hi_q <= '0;
      dma_q   <= '0;
      rkey_q  <= '0;
      imm_q   <= '0;
      flags_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        CA_PPM:   ppm_q   <= cfg_wdata_i[CNT_W-1:0];
        CA_NMSG:  nmsg_q  <= cfg_wdata_i[CNT_W-1:0];
        CA_SA_LO: sa_lo_q <= cfg_wdata_i;
        CA_SA_HI: sa_hi_q <= cfg_wdata_i;
        CA_DMA:   dma_q   <= cfg_wdata_i;
        CA_RKEY:  rkey_q  <= cfg_wdata_i;
        CA_IMM:   imm_q   <= cfg_wdata_i;
        CA_FLAGS: flags_q <= flags_t'(cfg_wdata_i[1:0]);
        CA_PAYLD: payld_q <= cfg_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  logic             accept, first, last;
  logic [DW-1:0]    msg_cnt;
  logic [CNT_W-1:0] msg_wrap;

  assign blk_ready_o = !hdr_valid_o && !cfg_we_i;
  assign accept      = blk_valid_i && blk_ready_o;

  rdma_hdr_cnt #(.CNT_W(CNT_W), .MSG_W(DW)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cfg_we_i),
    .step_i     (accept),
    .ppm_i      (ppm_q),
    .nmsg_i     (nmsg_q),
    .msg_cnt_o  (msg_cnt),
    .msg_wrap_o (msg_wrap),
    .first_o    (first),
    .last_o     (last)
  );

  logic [7:0]       op_d;
  logic             reth_d, imm_d;
  logic [LEN_W-1:0] hlen_d, frame_d;
  logic [AW-1:0]    vaddr_d;

  rdma_hdr_opsel #(.LEN_W(LEN_W)) i_opsel (
    .first_i    (first),
    .last_i     (last),
    .use_imm_i  (flags_q.use_imm),
    .opcode_o   (op_d),
    .has_reth_o (reth_d),
    .has_imm_o  (imm_d),
    .hdr_len_o  (hlen_d)
  );

  rdma_hdr_vaddr #(.AW(AW), .DW(DW), .IDX_W(CNT_W)) i_vaddr (
    .start_i   ({sa_hi_q, sa_lo_q}),
    .dma_len_i (dma_q),
    .idx_i     (msg_wrap),
    .vaddr_o   (vaddr_d)
  );

  assign frame_d = hlen_d + LEN_W'(payld_q) + LEN_W'(ICRC_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_valid_o    <= 1'b0;
      hdr_opcode_o   <= '0;
      hdr_psn_o      <= '0;
      hdr_has_reth_o <= 1'b0;
      hdr_vaddr_o    <= '0;
      hdr_rkey_o     <= '0;
      hdr_dma_len_o  <= '0;
      hdr_has_imm_o  <= 1'b0;
      hdr_imm_o      <= '0;
      hdr_len_o      <= '0;
      ip_total_len_o <= '0;
      udp_len_o      <= '0;
    end else if (accept) begin
      hdr_valid_o    <= 1'b1;
      hdr_opcode_o   <= op_d;
      hdr_psn_o      <= blk_bsn_i;
      hdr_has_reth_o <= reth_d;
      hdr_vaddr_o    <= vaddr_d;
      hdr_rkey_o     <= rkey_q;
      hdr_dma_len_o  <= dma_q;
      hdr_has_imm_o  <= imm_d;
      hdr_imm_o      <= flags_q.imm_is_cnt ? msg_cnt : imm_q;
      hdr_len_o      <= hlen_d;
      ip_total_len_o <= frame_d - LEN_W'(ETH_B);
      udp_len_o      <= frame_d - LEN_W'(ETH_IP_B);
    end else if (hdr_ack_i) begin
      hdr_valid_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/rdma_wr_hdr_seq_chk.sv
module rdma_wr_hdr_seq_chk #(
  parameter int PSN_W = 24,
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             blk_valid_i,
  input logic [PSN_W-1:0] blk_bsn_i,
  input logic             blk_ready_o,
  input logic             hdr_valid_o,
  input logic             hdr_ack_i,
  input logic [7:0]       hdr_opcode_o,
  input logic [PSN_W-1:0] hdr_psn_o,
  input logic             hdr_has_reth_o,
  input logic             hdr_has_imm_o,
  input logic [LEN_W-1:0] hdr_len_o,
  input logic [LEN_W-1:0] ip_total_len_o,
  input logic [LEN_W-1:0] udp_len_o
);
  AST_OPCODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (hdr_opcode_o >= 8'h26 && hdr_opcode_o <= 8'h2B)); // R1
  AST_PSN_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && blk_ready_o) |=> (hdr_valid_o && hdr_psn_o == $past(blk_bsn_i))); // R4
  AST_RETH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (hdr_has_reth_o == (hdr_opcode_o == 8'h26 || hdr_opcode_o == 8'h2A
                                        || hdr_opcode_o == 8'h2B))); // R5
  AST_IMM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (hdr_has_imm_o == (hdr_opcode_o == 8'h29 || hdr_opcode_o == 8'h2B))); // R7
  AST_HDR_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (hdr_len_o == LEN_W'(54) + (hdr_has_reth_o ? LEN_W'(16) : LEN_W'(0))
                                 + (hdr_has_imm_o ? LEN_W'(4) : LEN_W'(0)))); // R8
  AST_IP_UDP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (ip_total_len_o - udp_len_o == LEN_W'(20))); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o || cfg_we_i) |-> !blk_ready_o); // R9
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && !hdr_ack_i) |=> (hdr_valid_o && $stable(hdr_opcode_o)
                                     && $stable(hdr_psn_o) && $stable(hdr_len_o))); // R11
  AST_DROP_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && hdr_ack_i) |=> !hdr_valid_o); // R11
endmodule

bind rdma_wr_hdr_seq rdma_wr_hdr_seq_chk #(.PSN_W(PSN_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_rdma_wr_hdr_seq.sv
`timescale 1ns/1ps
module test_rdma_wr_hdr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        blk_valid = 1'b0;
  logic [23:0] blk_bsn = '0;
  logic        blk_ready, hdr_valid;
  logic        hdr_ack = 1'b0;
  logic [7:0]  op;
  logic [23:0] psn;
  logic        has_reth, has_imm;
  logic [63:0] vaddr;
  logic [31:0] rkey, dma_len, imm;
  logic [15:0] hlen, ip_len, udp_len;

  always #2.5 clk = ~clk;

  rdma_wr_hdr_seq i_rdma_wr_hdr_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .blk_valid_i(blk_valid), .blk_bsn_i(blk_bsn),
    .blk_ready_o(blk_ready), .hdr_valid_o(hdr_valid), .hdr_ack_i(hdr_ack),
    .hdr_opcode_o(op), .hdr_psn_o(psn), .hdr_has_reth_o(has_reth),
    .hdr_vaddr_o(vaddr), .hdr_rkey_o(rkey), .hdr_dma_len_o(dma_len),
    .hdr_has_imm_o(has_imm), .hdr_imm_o(imm), .hdr_len_o(hlen),
    .ip_total_len_o(ip_len), .udp_len_o(udp_len)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int unsigned m_ppm = 1, m_nmsg = 1, m_pay = 0, m_flags = 0;
  longint unsigned m_sa = 0;
  int unsigned m_dma = 0, m_rkey = 0, m_imm = 0;
  int unsigned m_pi = 0, m_msg = 0, m_wrap = 0;

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input int unsigned a, input int unsigned d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    #1 chk("R9 ready low during cfg write", blk_ready, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      0: m_ppm = d & 32'hFFFF;
      1: m_nmsg = d & 32'hFFFF;
      2: m_sa = {m_sa[63:32], d};
      3: m_sa = {d, m_sa[31:0]};
      4: m_dma = d;
      5: m_rkey = d;
      6: m_imm = d;
      7: m_flags = d & 3;
      8: m_pay = d & 32'hFFFF;
      default: ;
    endcase
    m_pi = 0; m_msg = 0; m_wrap = 0; // R10 / R13
  endtask

  // compare the presented header against the model, then advance the model
  task automatic expect_hdr(input logic [23:0] bsn);
    int unsigned ppe, nme, e_op, e_hlen, frame;
    bit first, last, use_imm, e_reth, e_imm;
    ppe = (m_ppm == 0) ? 1 : m_ppm;
    nme = (m_nmsg == 0) ? 1 : m_nmsg;
    use_imm = m_flags[0];
    first = (m_pi == 0);
    last  = (m_pi == ppe - 1);
    if (first && last) e_op = use_imm ? 'h2B : 'h2A;
    else if (first)    e_op = 'h26;
    else if (last)     e_op = use_imm ? 'h29 : 'h28;
    else               e_op = 'h27;
    e_reth = first;
    e_imm  = last && use_imm;
    e_hlen = 54 + (e_reth ? 16 : 0) + (e_imm ? 4 : 0);
    frame  = e_hlen + m_pay + 4;
    chk("R11 header valid", hdr_valid, 1);
    chk("R1/R2/R3 opcode", op, e_op);
    chk("R4 psn", psn, bsn);
    chk("R5 reth present", has_reth, e_reth);
    if (e_reth) begin
      chk("R6 virtual address", vaddr, m_sa + longint'(m_dma) * longint'(m_wrap));
      chk("R5 remote key", rkey, m_rkey);
      chk("R5 dma length", dma_len, m_dma);
    end
    chk("R7 imm present", has_imm, e_imm);
    if (e_imm) chk("R7 imm value", imm, m_flags[1] ? m_msg : m_imm);
    chk("R8 header length", hlen, e_hlen);
    chk("R8 ip total length", ip_len, frame - 14);
    chk("R8 udp length", udp_len, frame - 34);
    if (last) begin
      m_pi = 0; m_msg++;
      m_wrap = (m_wrap + 1 >= nme) ? 0 : m_wrap + 1;
    end else m_pi++;
  endtask

  task automatic send_blk(input logic [23:0] bsn, input int hold);
    @(negedge clk);
    chk("R9 ready before block", blk_ready, 1);
    blk_valid = 1'b1; blk_bsn = bsn;
    @(negedge clk);
    blk_valid = 1'b0;
    expect_hdr(bsn);
    for (int i = 0; i < hold; i++) begin
      blk_valid = 1'b1; blk_bsn = bsn ^ 24'hFFFFFF; // refused while pending
      @(negedge clk);
      chk("R11 valid held", hdr_valid, 1);
      chk("R11 psn held", psn, bsn);
      chk("R9 ready low while pending", blk_ready, 0);
    end
    blk_valid = 1'b0;
    hdr_ack = 1'b1;
    @(negedge clk);
    hdr_ack = 1'b0;
    chk("R11 valid drops after ack", hdr_valid, 0);
    chk("R11 ready back after ack", blk_ready, 1);
  endtask

  task automatic t_reset;
    #1;
    chk("R12 valid low in reset", hdr_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 valid low after reset", hdr_valid, 0);
    chk("R12 ready high after reset", blk_ready, 1);
    send_blk(24'h000011, 0); // defaults: ppm 1, flags 0 -> 0x2A, vaddr 0
  endtask

  task automatic t_multi_imm;
    cfg_wr(0, 4); cfg_wr(1, 3); cfg_wr(2, 32'h0000_1000); cfg_wr(3, 32'h0000_0001);
    cfg_wr(4, 32'h800); cfg_wr(5, 32'h55AA); cfg_wr(6, 32'hABADCAFE);
    cfg_wr(8, 256); cfg_wr(7, 1);
    for (int i = 0; i < 12; i++) send_blk(24'(100 + i), 0); // R1 R2 R6 wrap over 3 messages
  endtask

  task automatic t_last_plain;
    cfg_wr(0, 2); cfg_wr(7, 0);
    for (int i = 0; i < 4; i++) send_blk(24'(200 + i), 0); // R1 0x26 then 0x28
  endtask

  task automatic t_only_cnt;
    cfg_wr(0, 1); cfg_wr(1, 2); cfg_wr(7, 3);
    for (int i = 0; i < 4; i++) send_blk(24'hFFFFF0 + 24'(i), 0); // R3 R7 imm = message index
    cfg_wr(0, 0); cfg_wr(7, 0); cfg_wr(1, 0);
    for (int i = 0; i < 2; i++) send_blk(24'(300 + i), 0); // R3 ppm 0, R6 nmsg 0
  endtask

  task automatic t_hold;
    cfg_wr(0, 3); cfg_wr(7, 1); cfg_wr(1, 4);
    send_blk(24'h000400, 3); // R9 R11 refused blocks do not advance counters
    send_blk(24'h000401, 0);
    send_blk(24'h000402, 2);
  endtask

  task automatic t_clear;
    cfg_wr(0, 3); cfg_wr(7, 3); cfg_wr(1, 5);
    send_blk(24'h000500, 0);
    send_blk(24'h000501, 0);
    cfg_wr(6, 32'h1234); // R10 restart message mid-way
    send_blk(24'h000502, 0); // must be first again
    send_blk(24'h000503, 0);
    send_blk(24'h000504, 0);
    send_blk(24'h000505, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_multi_imm();
    t_last_plain();
    t_only_cnt();
    t_hold();
    t_clear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule